// File: doc/BRIEF.md
# Dual-Tone Keypad Waveform Synthesizer

This block produces the two-tone signalling waveform used by telephone keypads, one sample per strobe. A 4-bit key code picks one low-group and one high-group tone. Two phase accumulators step by fixed integer increments each time the one-cycle sample strobe arrives, which happens at 8 kHz in the intended system. Each phase drives a sine lookup that stores only a quarter wave and rebuilds the rest by symmetry. The two signed sine values are added, scaled down and offset into an unsigned DAC code, and the code appears together with a one-cycle valid pulse.

The strobe source, the DAC transfer and the analog side sit outside the block. The key code can change at any time, and the phases carry on across a change of key.

Top module: `dual_tone_synth`

## Requirements
- R1: After reset both phases are 0, out_valid is low and dac_code is 8192, the zero level. The first strobe after reset therefore yields the code for phases equal to the two selected steps.
- R2: The low-group phase step is selected by key_code[3:2]: 0→22, 1→25, 2→27, 3→30.
- R3: The high-group phase step is selected by key_code[1:0]: 0→39, 1→43, 2→47, 3→52.
- R4: Each phase is 8 bits and becomes (phase + step) mod 256 only on a cycle with sample_strobe high. With no strobe, out_valid stays low and dac_code holds its last value.
- R5: The sine of phase p uses a 64-entry table T[i] = floor(sin(i·π/128)·32767). For p in 0..63 it is T[p], for 64..127 it is T[127−p], for 128..191 it is −T[p−128], and for 192..255 it is −T[255−p].
- R6: dac_code = floor((sine_low + sine_high)/16) + 8192, where the division is an arithmetic right shift by 4 and so rounds toward minus infinity. The result is clamped to 0..16383.
- R7: A strobe sampled at clock edge k produces out_valid high for the single cycle after edge k+2, with the matching dac_code in that same cycle.
- R8: A new key_code takes effect at the next strobe. The phases keep accumulating from their current values and are not cleared.
- R9: Strobes on consecutive cycles each produce their own output on consecutive cycles. A key_code change in the same cycle as a strobe is used by that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_strobe | input | 1 | One-cycle request to advance both phases and produce a sample |
| key_code | input | 4 | Bits [3:2] select the low-group tone, bits [1:0] select the high-group tone |
| out_valid | output | 1 | One-cycle pulse marking a new dac_code |
| dac_code | output | 14 | Offset-binary DAC code |

## Verification
Two things can fall in the same cycle: a key change and the strobe that must use it, or a strobe arriving while earlier samples are still in the pipeline. The bench drives strobes on six consecutive cycles and changes the key on each of them. For every strobe it computes the expected code from the requirement formulas, using phases carried forward in its own model. The output on each of the following consecutive cycles must match the strobe three edges earlier. A key applied alongside the strobe must show up in that strobe's sample, and an earlier strobe's sample must not pick up the new key.

// File: rtl/dts_pkg.sv
package dts_pkg;

   typedef enum logic [1:0] {
      QD_RISE     = 2'd0,
      QD_FALL     = 2'd1,
      QD_NEG_RISE = 2'd2,
      QD_NEG_FALL = 2'd3
   } quadrant_e;

   // base increment for an 8-bit phase circle
   function automatic int base_step(input logic high_grp, input logic [1:0] sel);
      int s;
      if (!high_grp) begin
         case (sel)
            2'd0:    s = 22;
            2'd1:    s = 25;
            2'd2:    s = 27;
            default: s = 30;
         endcase
      end else begin
         case (sel)
            2'd0:    s = 39;
            2'd1:    s = 43;
            2'd2:    s = 47;
            default: s = 52;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/dts_phase_acc.sv
module dts_phase_acc #(
   parameter int PHASE_W  = 8,
   parameter bit HIGH_GRP = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               advance,
   input  logic [1:0]         sel,
   output logic [PHASE_W-1:0] phase
);
   localparam int SCALE = PHASE_W - 8;

   logic [PHASE_W-1:0] step;

   always_comb begin
      step = PHASE_W'(dts_pkg::base_step(HIGH_GRP, sel)) << SCALE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (advance) begin
         phase <= phase + step;
      end
   end
endmodule

// File: rtl/dts_sine_fold.sv
module dts_sine_fold #(
   parameter int PHASE_W = 8,
   parameter int AMP_W   = 16
) (
   input  logic [PHASE_W-1:0]      phase,
   output logic signed [AMP_W-1:0] sine
);
   localparam int  IDX_W   = PHASE_W - 2;
   localparam int  DEPTH   = 1 << IDX_W;
   localparam int  PEAK    = (1 << (AMP_W - 1)) - 1;
   localparam real QTR_ARC = 1.5707963267948966;

   logic signed [AMP_W-1:0] qtable [DEPTH];

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_tab
         localparam int VAL =
            $rtoi($sin(real'(gi) * QTR_ARC / real'(DEPTH)) * real'(PEAK));
         assign qtable[gi] = AMP_W'(VAL);
      end
   endgenerate

   dts_pkg::quadrant_e quad;
   logic [IDX_W-1:0]   idx;
   logic [IDX_W-1:0]   addr;
   logic signed [AMP_W-1:0] mag;

   always_comb begin
      quad = dts_pkg::quadrant_e'(phase[PHASE_W-1 -: 2]);
      idx  = phase[IDX_W-1:0];
      case (quad)
         dts_pkg::QD_FALL, dts_pkg::QD_NEG_FALL: addr = ~idx;
         default:                                addr = idx;
      endcase
      mag = qtable[addr];
      case (quad)
         dts_pkg::QD_NEG_RISE, dts_pkg::QD_NEG_FALL: sine = -mag;
         default:                                    sine = mag;
      endcase
   end
endmodule

// File: rtl/dts_dac_scale.sv
module dts_dac_scale #(
   parameter int AMP_W = 16,
   parameter int DAC_W = 14
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [AMP_W-1:0] sine_a,
   input  logic signed [AMP_W-1:0] sine_b,
   output logic                    out_valid,
   output logic [DAC_W-1:0]        dac_code
);
   localparam int SUM_W  = AMP_W + 2;
   localparam int SHIFT  = SUM_W - DAC_W;
   localparam int ZERO_I = 1 << (DAC_W - 1);
   localparam int MAX_I  = (1 << DAC_W) - 1;

   logic signed [SUM_W-1:0] sum;
   logic signed [SUM_W-1:0] scaled;
   logic signed [SUM_W-1:0] biased;
   logic [DAC_W-1:0]        clamped;

   always_comb begin
      sum    = SUM_W'(sine_a) + SUM_W'(sine_b);
      scaled = sum >>> SHIFT;
      biased = scaled + SUM_W'(ZERO_I);
      if (biased < 0) begin
         clamped = '0;
      end else if (biased > SUM_W'(MAX_I)) begin
         clamped = DAC_W'(MAX_I);
      end else begin
         clamped = biased[DAC_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         dac_code  <= DAC_W'(ZERO_I);
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            dac_code <= clamped;
         end
      end
   end
endmodule

// File: rtl/dual_tone_synth.sv
module dual_tone_synth #(
   parameter int PHASE_W  = 8,
   parameter int AMP_W    = 16,
   parameter int DAC_W    = 14,
   parameter bit REG_FOLD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_strobe,
   input  logic [3:0]       key_code,
   output logic             out_valid,
   output logic [DAC_W-1:0] dac_code
);
   localparam int N_TONES = 2;

   generate
      if (PHASE_W < 8 || PHASE_W > 12) begin : g_bad_phase
         $fatal(1, "PHASE_W must lie in 8..12");
      end
      if (DAC_W > AMP_W + 1 || DAC_W < 4) begin : g_bad_dac
         $fatal(1, "DAC_W must lie in 4..AMP_W+1");
      end
      if (AMP_W < 8) begin : g_bad_amp
         $fatal(1, "AMP_W must be at least 8");
      end
   endgenerate

   logic [PHASE_W-1:0]      phase_v [N_TONES];
   logic signed [AMP_W-1:0] sine_v  [N_TONES];
   logic signed [AMP_W-1:0] sine_p  [N_TONES];
   logic                    adv_q;
   logic                    fold_valid;
   logic [PHASE_W-1:0]      row_phase;
   logic [PHASE_W-1:0]      col_phase;

   genvar gt;
   generate
      for (gt = 0; gt < N_TONES; gt++) begin : g_tone
         dts_phase_acc #(
            .PHASE_W (PHASE_W),
            .HIGH_GRP(gt == 1)
         ) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .advance(sample_strobe),
            .sel    (key_code[3 - 2*gt -: 2]),
            .phase  (phase_v[gt])
         );

         dts_sine_fold #(
            .PHASE_W(PHASE_W),
            .AMP_W  (AMP_W)
         ) u_fold (
            .phase(phase_v[gt]),
            .sine (sine_v[gt])
         );
      end
   endgenerate

   assign row_phase = phase_v[0];
   assign col_phase = phase_v[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adv_q <= 1'b0;
      end else begin
         adv_q <= sample_strobe;
      end
   end

   generate
      if (REG_FOLD) begin : g_fold_reg
         logic                    fold_q;
         logic signed [AMP_W-1:0] sine_q [N_TONES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fold_q <= 1'b0;
               for (int t = 0; t < N_TONES; t++) begin
                  sine_q[t] <= '0;
               end
            end else begin
               fold_q <= adv_q;
               if (adv_q) begin
                  for (int t = 0; t < N_TONES; t++) begin
                     sine_q[t] <= sine_v[t];
                  end
               end
            end
         end
         assign fold_valid = fold_q;
         for (gt = 0; gt < N_TONES; gt++) begin : g_pass
            assign sine_p[gt] = sine_q[gt];
         end
      end else begin : g_fold_comb
         assign fold_valid = adv_q;
         for (gt = 0; gt < N_TONES; gt++) begin : g_pass
            assign sine_p[gt] = sine_v[gt];
         end
      end
   endgenerate

   dts_dac_scale #(
      .AMP_W(AMP_W),
      .DAC_W(DAC_W)
   ) u_scale (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (fold_valid),
      .sine_a   (sine_p[0]),
      .sine_b   (sine_p[1]),
      .out_valid(out_valid),
      .dac_code (dac_code)
   );
endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
   parameter int PHASE_W = 8,
   parameter int DAC_W   = 14,
   parameter int LAT     = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sample_strobe,
   input logic [3:0]         key_code,
   input logic               out_valid,
   input logic [DAC_W-1:0]   dac_code,
   input logic [PHASE_W-1:0] row_phase,
   input logic [PHASE_W-1:0] col_phase
);
   logic [2:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
      end else if (since_rst != 3'd7) begin
         since_rst <= since_rst + 3'd1;
      end
   end

   function automatic logic [PHASE_W-1:0] ref_step(input logic hi, input logic [1:0] s);
      return PHASE_W'(dts_pkg::base_step(hi, s)) << (PHASE_W - 8);
   endfunction

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(since_rst) >= LAT) |-> (out_valid == $past(sample_strobe, LAT))); // R7

   AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 3'd0 && !out_valid) |-> $stable(dac_code)); // R4

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 3'd0 && !$past(sample_strobe)) |-> ($stable(row_phase) && $stable(col_phase))); // R4

   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 3'd0 && $past(sample_strobe))
         |-> (row_phase == $past(row_phase) + ref_step(1'b0, $past(key_code[3:2])))); // R2

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 3'd0 && $past(sample_strobe))
         |-> (col_phase == $past(col_phase) + ref_step(1'b1, $past(key_code[1:0])))); // R3
endmodule

bind dual_tone_synth dts_checker #(
   .PHASE_W(PHASE_W),
   .DAC_W  (DAC_W),
   .LAT    (REG_FOLD ? 3 : 2)
) u_dts_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .sample_strobe(sample_strobe),
   .key_code     (key_code),
   .out_valid    (out_valid),
   .dac_code     (dac_code),
   .row_phase    (row_phase),
   .col_phase    (col_phase)
);

// File: tb/tb_dual_tone_synth.sv
`timescale 1ns/1ps
module tb_dual_tone_synth;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_strobe = 1'b0;
   logic [3:0]  key_code = 4'd0;
   logic        out_valid;
   logic [13:0] dac_code;

   int n_vec = 0;
   int n_bad = 0;
   int m_row = 0;
   int m_col = 0;
   int last_code = 8192;

   always #5 clk = ~clk;

   dual_tone_synth dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_strobe(sample_strobe),
      .key_code     (key_code),
      .out_valid    (out_valid),
      .dac_code     (dac_code)
   );

   function automatic int tbl(input int i);
      return $rtoi($sin(real'(i) * 3.141592653589793 / 128.0) * 32767.0);
   endfunction

   function automatic int sine_of(input int p);
      if (p < 64)       return tbl(p);
      else if (p < 128) return tbl(127 - p);
      else if (p < 192) return -tbl(p - 128);
      else              return -tbl(255 - p);
   endfunction

   function automatic int row_inc(input int s);
      int r [4] = '{22, 25, 27, 30};
      return r[s];
   endfunction

   function automatic int col_inc(input int s);
      int c [4] = '{39, 43, 47, 52};
      return c[s];
   endfunction

   // advance the model by one strobe and return the expected code
   function automatic int model_step(input int key);
      int s;
      int code;
      m_row = (m_row + row_inc((key >> 2) & 3)) % 256;
      m_col = (m_col + col_inc(key & 3)) % 256;
      s = sine_of(m_row) + sine_of(m_col);
      code = (s >>> 4) + 8192;
      if (code < 0) code = 0;
      if (code > 16383) code = 16383;
      return code;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sample_strobe = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_row = 0;
      m_col = 0;
      last_code = 8192;
   endtask

   // one isolated strobe, checking the latency window and the value
   task automatic one_sample(input int key, input string req);
      int exp;
      @(negedge clk);
      key_code = 4'(key);
      sample_strobe = 1'b1;
      exp = model_step(key);
      @(negedge clk);
      sample_strobe = 1'b0;
      if (out_valid !== 1'b0) check({req, " R7 early"}, int'(out_valid), 0);
      @(negedge clk);
      if (out_valid !== 1'b0) check({req, " R7 early"}, int'(out_valid), 0);
      @(negedge clk);
      check({req, " R7 valid"}, int'(out_valid), 1);
      check(req, int'(dac_code), exp);
      last_code = exp;
      @(negedge clk);
      check({req, " R7 single pulse"}, int'(out_valid), 0);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 valid after reset", int'(out_valid), 0);
      check("R1 zero level", int'(dac_code), 8192);
      one_sample(0, "R1 first sample");
   endtask

   task automatic t_all_keys();
      for (int k = 0; k < 16; k++) begin
         one_sample(k, "R2 R3 R5 R6 key sweep");
      end
   endtask

   task automatic t_idle();
      key_code = 4'd9;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check("R4 idle valid", int'(out_valid), 0);
         check("R4 idle hold", int'(dac_code), last_code);
      end
      one_sample(9, "R4 phase kept across idle");
   endtask

   task automatic t_wrap();
      for (int i = 0; i < 30; i++) begin
         one_sample(15, "R4 R5 wrap and quadrants");
      end
      for (int i = 0; i < 20; i++) begin
         one_sample(0, "R5 R6 low steps");
      end
   endtask

   task automatic t_key_change();
      for (int i = 0; i < 4; i++) one_sample(5, "R8 before change");
      for (int i = 0; i < 4; i++) one_sample(10, "R8 after change");
   endtask

   task automatic t_back_to_back();
      int exp [6];
      int keys [6] = '{3, 12, 6, 9, 0, 15};
      for (int t = 0; t < 10; t++) begin
         @(negedge clk);
         if (t >= 3 && t < 9) begin
            check("R9 back-to-back valid", int'(out_valid), 1);
            check("R9 back-to-back code", int'(dac_code), exp[t-3]);
            last_code = exp[t-3];
         end else if (t >= 1) begin
            check("R9 no spurious valid", int'(out_valid), 0);
         end
         if (t < 6) begin
            key_code = 4'(keys[t]);
            sample_strobe = 1'b1;
            exp[t] = model_step(keys[t]);
         end else begin
            sample_strobe = 1'b0;
         end
      end
   endtask

   task automatic t_reset_midrun();
      do_reset();
      check("R1 zero level after second reset", int'(dac_code), 8192);
      one_sample(6, "R1 phases restart");
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #200000;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_all_keys();
      t_idle();
      t_wrap();
      t_key_change();
      t_back_to_back();
      t_reset_midrun();
      finish_run();
   end
endmodule